// File: doc/BRIEF.md
# Channel Map and Result Send Unit

Each core has one of these units. It turns the small logical output-channel numbers that instructions name into on-chip network destinations, and it injects instruction results into the network. A sixteen-entry map table holds the destinations. A dedicated set-map instruction writes a destination into one chosen entry through the configuration port. The decode stage reads the table combinationally. The mapped destination and its multicast flag then travel down the pipeline with the instruction.

At writeback, an instruction that names an output channel presents its result on the send port. The unit forwards it as one flit. The flit carries the destination, the multicast flag, the data and an end-of-packet marker. Sends to a single remote buffer are paced by a credit counter kept per channel entry. A credit is used for every accepted flit, and the separate credit network returns credits one at a time. A multicast destination is a bit mask of the cores in the tile: bit i stands for core i. A multicast send uses no credits. It is offered only while every addressed core shows ready.

The send port and the network port are valid/ready pairs. A flit moves on a cycle where `net_valid` and `net_ready` are both high. `wb_ready` is high exactly when the unit could forward a flit on that cycle. It does not wait for `wb_valid`. `net_valid` never rises without `wb_valid`. The writeback stage must hold `wb_*` steady until `wb_ready` is seen. Credit returns and table writes are single-cycle strobes with no back-pressure.

Top module: `chan_send_unit`

## Requirements
- R1: After reset, every table entry reads as destination 0 with the multicast flag clear, every entry holds CREDITS credits, and `net_valid` is low while `wb_valid` is low.
- R2: A table write (`cfg_valid` high at a clock edge) to entry `cfg_ch` makes later decode reads of that entry return `cfg_dest` and `cfg_mcast`. Other entries are left unchanged.
- R3: A decode read of the entry being written in the same cycle returns the value being written. A read of any other entry returns its stored value.
- R4: For a unicast send with a credit available, `net_valid` equals `wb_valid`. `net_dest`, `net_mcast`, `net_data` and `net_eop` equal the corresponding `wb_*` inputs.
- R5: Each accepted unicast flit removes one credit from entry `wb_ch`. Exactly CREDITS flits pass from a full entry. After that, `net_valid` and `wb_ready` stay low until a credit comes back.
- R6: A credit return (`cr_valid` on entry `cr_ch`) adds one credit. A return and an accepted send on the same entry in the same cycle leave the count unchanged. A return to a full entry is dropped, so the count never exceeds CREDITS.
- R7: A multicast send (`wb_mcast` high, target mask in the low NCORES bits of `wb_dest`) is offered exactly when `core_rdy` is high for every bit set in the mask. It uses no credits.
- R8: A table write to an entry also refills that entry's credit count to CREDITS.
- R9: `wb_ready` is low whenever `net_ready` is low, and no credit is used on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Table write strobe from the set-map instruction |
| cfg_ch | input | 4 | Entry to write |
| cfg_mcast | input | 1 | Multicast flag to store |
| cfg_dest | input | 8 | Destination address or core mask to store |
| dec_ch | input | 4 | Entry read by decode |
| dec_mcast | output | 1 | Multicast flag of the entry read |
| dec_dest | output | 8 | Destination of the entry read |
| wb_valid | input | 1 | Result flit offered at writeback |
| wb_ready | output | 1 | Unit can take the flit this cycle |
| wb_ch | input | 4 | Channel the instruction named (selects credits) |
| wb_mcast | input | 1 | Multicast flag carried from decode |
| wb_dest | input | 8 | Destination carried from decode |
| wb_data | input | 32 | Result value |
| wb_eop | input | 1 | End-of-packet marker of the instruction |
| net_valid | output | 1 | Flit offered to the network |
| net_ready | input | 1 | Network accepts the flit |
| net_mcast | output | 1 | Flit is multicast |
| net_dest | output | 8 | Flit destination |
| net_data | output | 32 | Flit payload |
| net_eop | output | 1 | Flit closes a packet |
| cr_valid | input | 1 | One credit returned |
| cr_ch | input | 4 | Entry the credit belongs to |
| core_rdy | input | 8 | Per-core ready of tile cores for multicast |

## Verification
A wrong credit count shows up at the ports in one way only: the number of back-to-back flits a channel lets through before `wb_ready` drops. An off-by-one counter therefore shows within CREDITS+1 cycles of a burst on that channel. A missing refill or a bad saturation shows in the next burst after the write or the surplus return. A corrupted table entry shows on the very next decode read of that entry. A wrong bypass shows only in the cycle where the write and the read meet. A faulty multicast gate shows as a wrong `net_valid` for some `core_rdy` pattern in the same cycle, so all patterns are swept for each mask.

// File: rtl/chsend_pkg.sv
`timescale 1ns/1ps
package chsend_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_ADDR_W  = 8;
  localparam int unsigned DEF_CORES   = 8;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_CREDITS = 4;

  typedef enum logic {
    SEND_UNICAST   = 1'b0,
    SEND_MULTICAST = 1'b1
  } send_kind_e;
endpackage

// File: rtl/chmap_table.sv
`timescale 1ns/1ps
module chmap_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_mcast,
  input  logic [ADDR_W-1:0] wr_dest,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_mcast,
  output logic [ADDR_W-1:0] rd_dest
);
  logic              mc_q   [ENTRIES];
  logic [ADDR_W-1:0] dest_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mc_q[e]   <= 1'b0;
        dest_q[e] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        mc_q[e]   <= wr_mcast;
        dest_q[e] <= wr_dest;
      end
    end
  end

  // write-through: a same-cycle write to the read entry wins
  always_comb begin
    if (wr_en && wr_idx == rd_idx) begin
      rd_mcast = wr_mcast;
      rd_dest  = wr_dest;
    end else begin
      rd_mcast = mc_q[rd_idx];
      rd_dest  = dest_q[rd_idx];
    end
  end
endmodule

// File: rtl/chmap_credits.sv
`timescale 1ns/1ps
module chmap_credits #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned CREDITS = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(CREDITS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_en,
  input  logic [IDX_W-1:0]         take_idx,
  input  logic                     give_en,
  input  logic [IDX_W-1:0]         give_idx,
  input  logic                     fill_en,
  input  logic [IDX_W-1:0]         fill_idx,
  input  logic [IDX_W-1:0]         query_idx,
  output logic                     query_ok,
  output logic [ENTRIES*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CREDITS);

  logic [CNT_W-1:0] cnt_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
    logic take_hit, give_hit;
    assign take_hit = take_en && take_idx == IDX_W'(e);
    assign give_hit = give_en && give_idx == IDX_W'(e);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[e] <= FULL;
      end else if (fill_en && fill_idx == IDX_W'(e)) begin
        cnt_q[e] <= FULL;
      end else begin
        unique case ({take_hit, give_hit})
          2'b10:   cnt_q[e] <= cnt_q[e] - 1'b1;
          2'b01:   if (cnt_q[e] != FULL) cnt_q[e] <= cnt_q[e] + 1'b1;
          default: cnt_q[e] <= cnt_q[e];
        endcase
      end
    end

    assign cnt_flat[e*CNT_W +: CNT_W] = cnt_q[e];
  end

  assign query_ok = cnt_q[query_idx] != '0;
endmodule

// File: rtl/chmap_sender.sv
`timescale 1ns/1ps
module chmap_sender
  import chsend_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CORES  = 8
) (
  input  logic              wb_valid,
  input  logic              wb_mcast,
  input  logic [ADDR_W-1:0] wb_dest,
  input  logic              credit_ok,
  input  logic [CORES-1:0]  core_rdy,
  input  logic              net_ready,
  output logic              net_valid,
  output logic              wb_ready,
  output logic              take_credit
);
  logic [CORES-1:0] target_mask;
  send_kind_e       kind;
  logic             may_go;

  if (ADDR_W >= CORES) begin : g_mask_slice
    assign target_mask = wb_dest[CORES-1:0];
  end else begin : g_mask_pad
    assign target_mask = {{(CORES-ADDR_W){1'b0}}, wb_dest};
  end

  assign kind = send_kind_e'(wb_mcast);

  always_comb begin
    unique case (kind)
      SEND_MULTICAST: may_go = (core_rdy & target_mask) == target_mask;
      default:        may_go = credit_ok;
    endcase
  end

  assign net_valid   = wb_valid && may_go;
  assign wb_ready    = net_ready && may_go;
  assign take_credit = net_valid && net_ready && (kind == SEND_UNICAST);
endmodule

// File: rtl/chan_send_unit.sv
`timescale 1ns/1ps
module chan_send_unit
  import chsend_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned CORES   = DEF_CORES,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned CREDITS = DEF_CREDITS,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [IDX_W-1:0]  cfg_ch,
  input  logic              cfg_mcast,
  input  logic [ADDR_W-1:0] cfg_dest,
  input  logic [IDX_W-1:0]  dec_ch,
  output logic              dec_mcast,
  output logic [ADDR_W-1:0] dec_dest,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [IDX_W-1:0]  wb_ch,
  input  logic              wb_mcast,
  input  logic [ADDR_W-1:0] wb_dest,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_eop,
  output logic              net_valid,
  input  logic              net_ready,
  output logic              net_mcast,
  output logic [ADDR_W-1:0] net_dest,
  output logic [DATA_W-1:0] net_data,
  output logic              net_eop,
  input  logic              cr_valid,
  input  logic [IDX_W-1:0]  cr_ch,
  input  logic [CORES-1:0]  core_rdy
);
  logic                     credit_ok;
  logic                     take_credit;
  logic [ENTRIES*CNT_W-1:0] cred_flat;

  chmap_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_valid),
    .wr_idx   (cfg_ch),
    .wr_mcast (cfg_mcast),
    .wr_dest  (cfg_dest),
    .rd_idx   (dec_ch),
    .rd_mcast (dec_mcast),
    .rd_dest  (dec_dest)
  );

  chmap_credits #(.ENTRIES(ENTRIES), .CREDITS(CREDITS)) u_credits (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_en   (take_credit),
    .take_idx  (wb_ch),
    .give_en   (cr_valid),
    .give_idx  (cr_ch),
    .fill_en   (cfg_valid),
    .fill_idx  (cfg_ch),
    .query_idx (wb_ch),
    .query_ok  (credit_ok),
    .cnt_flat  (cred_flat)
  );

  chmap_sender #(.ADDR_W(ADDR_W), .CORES(CORES)) u_sender (
    .wb_valid    (wb_valid),
    .wb_mcast    (wb_mcast),
    .wb_dest     (wb_dest),
    .credit_ok   (credit_ok),
    .core_rdy    (core_rdy),
    .net_ready   (net_ready),
    .net_valid   (net_valid),
    .wb_ready    (wb_ready),
    .take_credit (take_credit)
  );

  assign net_mcast = wb_mcast;
  assign net_dest  = wb_dest;
  assign net_data  = wb_data;
  assign net_eop   = wb_eop;
endmodule

// File: rtl/chan_send_chk.sv
`timescale 1ns/1ps
module chan_send_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CORES   = 8,
  parameter int unsigned CREDITS = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(CREDITS + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_valid,
  input logic [IDX_W-1:0]         cfg_ch,
  input logic                     cfg_mcast,
  input logic [ADDR_W-1:0]        cfg_dest,
  input logic [IDX_W-1:0]         dec_ch,
  input logic                     dec_mcast,
  input logic [ADDR_W-1:0]        dec_dest,
  input logic                     wb_valid,
  input logic                     wb_ready,
  input logic [IDX_W-1:0]         wb_ch,
  input logic                     net_valid,
  input logic                     net_ready,
  input logic                     net_mcast,
  input logic [ADDR_W-1:0]        net_dest,
  input logic                     cr_valid,
  input logic [IDX_W-1:0]         cr_ch,
  input logic [CORES-1:0]         core_rdy,
  input logic [ENTRIES*CNT_W-1:0] cred_flat
);
  logic [CNT_W-1:0] cur_cred;
  logic [CORES-1:0] cur_mask;
  logic             plain_take;

  assign cur_cred = cred_flat[wb_ch*CNT_W +: CNT_W];
  assign cur_mask = CORES'(net_dest);
  assign plain_take = net_valid && net_ready && !net_mcast
                      && !(cr_valid && cr_ch == wb_ch)
                      && !(cfg_valid && cfg_ch == wb_ch);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_bound
    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cred_flat[e*CNT_W +: CNT_W] <= CNT_W'(CREDITS)); // R6
  end

  AST_NO_DRY_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && !net_mcast) |-> cur_cred != '0); // R5

  AST_CREDIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    plain_take |=> cred_flat[$past(wb_ch)*CNT_W +: CNT_W]
                   == $past(cur_cred) - 1'b1); // R5

  AST_VALID_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> wb_valid); // R4

  AST_READY_FROM_NET: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ready |-> net_ready); // R9

  AST_MCAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && net_mcast) |-> (core_rdy & cur_mask) == cur_mask); // R7

  AST_WRITE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ch == dec_ch) |->
      (dec_dest == cfg_dest && dec_mcast == cfg_mcast)); // R3

  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !(cfg_valid && $past(cfg_valid) == 1'b0 && 1'b0)) |=>
      (dec_ch == $past(cfg_ch)) |-> dec_dest == $past(cfg_dest)
                                   || (cfg_valid && cfg_ch == dec_ch)); // R2
endmodule

bind chan_send_unit chan_send_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CORES(CORES), .CREDITS(CREDITS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_valid(cfg_valid), .cfg_ch(cfg_ch), .cfg_mcast(cfg_mcast), .cfg_dest(cfg_dest),
  .dec_ch(dec_ch), .dec_mcast(dec_mcast), .dec_dest(dec_dest),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_ch(wb_ch),
  .net_valid(net_valid), .net_ready(net_ready), .net_mcast(net_mcast), .net_dest(net_dest),
  .cr_valid(cr_valid), .cr_ch(cr_ch), .core_rdy(core_rdy),
  .cred_flat(cred_flat)
);

// File: tb/tb_chan_send_unit.sv
`timescale 1ns/1ps
module tb_chan_send_unit;
  localparam int ENTRIES = 16;
  localparam int CREDITS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, cfg_mcast = 1'b0;
  logic [3:0]  cfg_ch = '0, dec_ch = '0, wb_ch = '0, cr_ch = '0;
  logic [7:0]  cfg_dest = '0, wb_dest = '0, core_rdy = '0;
  logic        dec_mcast, wb_ready, net_valid, net_mcast, net_eop;
  logic [7:0]  dec_dest, net_dest;
  logic [31:0] net_data, wb_data = '0;
  logic        wb_valid = 1'b0, wb_mcast = 1'b0, wb_eop = 1'b0;
  logic        net_ready = 1'b1, cr_valid = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chan_send_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ch(cfg_ch), .cfg_mcast(cfg_mcast), .cfg_dest(cfg_dest),
    .dec_ch(dec_ch), .dec_mcast(dec_mcast), .dec_dest(dec_dest),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_ch(wb_ch), .wb_mcast(wb_mcast),
    .wb_dest(wb_dest), .wb_data(wb_data), .wb_eop(wb_eop),
    .net_valid(net_valid), .net_ready(net_ready), .net_mcast(net_mcast),
    .net_dest(net_dest), .net_data(net_data), .net_eop(net_eop),
    .cr_valid(cr_valid), .cr_ch(cr_ch), .core_rdy(core_rdy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dest_of(input int ch);
    return 8'((ch * 37 + 5) & 8'hFF);
  endfunction

  task automatic write_entry(input int ch, input bit mc, input logic [7:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ch = 4'(ch); cfg_mcast = mc; cfg_dest = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic give_credit(input int ch);
    @(negedge clk);
    cr_valid = 1'b1; cr_ch = 4'(ch);
    @(negedge clk);
    cr_valid = 1'b0;
  endtask

  // burst of unicast sends on one channel; returns how many flits passed
  task automatic burst(input int ch, output int n);
    n = 0;
    @(negedge clk);
    wb_valid = 1'b1; wb_ch = 4'(ch); wb_mcast = 1'b0; wb_dest = dest_of(ch);
    for (int i = 0; i < CREDITS + 3; i++) begin
      wb_data = 32'(ch * 1000 + i);
      wb_eop  = (i == CREDITS - 1);
      #1;
      if (!net_valid) begin
        check(wb_ready == 1'b0, "R5 stall ready", wb_ready, 0);
        break;
      end
      check(net_data == 32'(ch * 1000 + i) && net_dest == dest_of(ch) && !net_mcast,
            "R4 fields", net_data, ch * 1000 + i);
      check(net_eop == (i == CREDITS - 1), "R4 eop", net_eop, i == CREDITS - 1);
      n++;
      @(negedge clk);
    end
    wb_valid = 1'b0;
  endtask

  task automatic mcast_sweep(input logic [7:0] mask);
    write_entry(12, 1'b1, mask);
    @(negedge clk);
    wb_valid = 1'b1; wb_ch = 4'd12; wb_mcast = 1'b1; wb_dest = mask;
    for (int r = 0; r < 256; r++) begin
      core_rdy = 8'(r);
      #1;
      check(net_valid == ((8'(r) & mask) == mask), "R7 gate", net_valid,
            (8'(r) & mask) == mask);
      check(wb_ready == ((8'(r) & mask) == mask), "R7 ready", wb_ready,
            (8'(r) & mask) == mask);
      @(negedge clk);
    end
    core_rdy = 8'hFF;
    for (int i = 0; i < 3 * CREDITS; i++) begin
      #1;
      check(net_valid && net_mcast, "R7 no credit use", net_valid, 1);
      @(negedge clk);
    end
    wb_valid = 1'b0; wb_mcast = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int ch = 0; ch < ENTRIES; ch++) begin
      dec_ch = 4'(ch);
      #1;
      check(dec_dest == 8'd0 && dec_mcast == 1'b0, "R1 table", dec_dest, 0);
    end
    check(net_valid == 1'b0, "R1 idle", net_valid, 0);
    burst(0, n);
    check(n == CREDITS, "R1 credits", n, CREDITS);

    // R2: fill whole table
    for (int ch = 0; ch < ENTRIES; ch++) write_entry(ch, 1'b0, dest_of(ch));
    for (int ch = 0; ch < ENTRIES; ch++) begin
      @(negedge clk);
      dec_ch = 4'(ch);
      #1;
      check(dec_dest == dest_of(ch) && !dec_mcast, "R2 read", dec_dest, dest_of(ch));
    end

    // R3: bypass on same entry, stored value on another
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ch = 4'd5; cfg_mcast = 1'b1; cfg_dest = 8'hA5; dec_ch = 4'd5;
    #1;
    check(dec_dest == 8'hA5 && dec_mcast, "R3 bypass", dec_dest, 8'hA5);
    dec_ch = 4'd6;
    #1;
    check(dec_dest == dest_of(6) && !dec_mcast, "R3 other", dec_dest, dest_of(6));
    @(negedge clk);
    cfg_valid = 1'b0;
    write_entry(5, 1'b0, dest_of(5));

    // R4/R5: every channel passes exactly CREDITS flits
    for (int ch = 0; ch < ENTRIES; ch++) begin
      burst(ch, n);
      check(n == CREDITS, "R5 burst length", n, CREDITS);
    end

    // R6: single return, simultaneous send+return, saturation
    give_credit(3);
    burst(3, n);
    check(n == 1, "R6 one return", n, 1);
    give_credit(3);
    @(negedge clk);
    wb_valid = 1'b1; wb_ch = 4'd3; wb_mcast = 1'b0; wb_dest = dest_of(3);
    cr_valid = 1'b1; cr_ch = 4'd3;
    #1;
    check(net_valid == 1'b1, "R6 send with credit", net_valid, 1);
    @(negedge clk);
    wb_valid = 1'b0; cr_valid = 1'b0;
    burst(3, n);
    check(n == 1, "R6 net zero change", n, 1);

    // R8: rewrite refills
    write_entry(7, 1'b0, dest_of(7));
    burst(7, n);
    check(n == CREDITS, "R8 refill", n, CREDITS);
    for (int i = 0; i < CREDITS + 2; i++) give_credit(7);
    burst(7, n);
    check(n == CREDITS, "R6 saturate", n, CREDITS);

    // R9: no transfer while network stalls
    write_entry(9, 1'b0, dest_of(9));
    @(negedge clk);
    net_ready = 1'b0;
    wb_valid = 1'b1; wb_ch = 4'd9; wb_mcast = 1'b0; wb_dest = dest_of(9);
    for (int i = 0; i < 3; i++) begin
      #1;
      check(wb_ready == 1'b0 && net_valid == 1'b1, "R9 stall", wb_ready, 0);
      @(negedge clk);
    end
    wb_valid = 1'b0; net_ready = 1'b1;
    burst(9, n);
    check(n == CREDITS, "R9 no credit used", n, CREDITS);

    // R7: multicast gating over all ready patterns
    mcast_sweep(8'h5A);
    mcast_sweep(8'h81);
    mcast_sweep(8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule